// File: doc/BRIEF.md
# Segmented Split-Bank Memory Access Sequencer

This block forms a 20-bit physical byte address from one of four 16-bit segment bases and a 16-bit offset. The base is scaled by sixteen and the offset is added to it. The block then carries out one byte or word read or write against a memory split into an even-byte bank and an odd-byte bank, and each bank has its own enable. A word that starts on an even address moves in a single bus cycle with both banks enabled. A word that starts on an odd address is split into two byte cycles. The first cycle carries the low byte at the odd address. The second carries the high byte at the next, even address.

The parameter `BUS8` selects a narrow variant with an 8-bit, single-bank memory. In that variant only the low data lane and the even enable are used, and every word costs two byte cycles. The block takes one request at a time. `req_ready_o` shows that it can accept a request. `done_o` pulses once the last bus cycle has finished, and read data is presented right-aligned alongside it.

The sequencer has four states. In `ST_IDLE` it is ready and accepts a request. In `ST_FIRST` it runs the first bus cycle. In `ST_SECOND` it runs the second byte cycle of a split word. In `ST_DONE` it asserts the completion pulse. Its transitions are:

- IDLE to FIRST, on an accepted request.
- FIRST to SECOND, when the word is split.
- FIRST to DONE, otherwise.
- SECOND to DONE, always.
- DONE to IDLE, always.

Top module: `seg_mem_seq`

## Requirements
- R1: The physical address is (segment base × 16 + offset) mod 2^20. `req_seg_i` picks the base as follows: 0 code, 1 data, 2 extra, 3 stack. Base i is taken from bits [16i+15:16i] of `seg_bases_i`. The first bus cycle drives this address on `mem_addr_o`.
- R2: `req_ready_o` is high only in the idle state. A request is accepted on the clock edge where `req_valid_i` and `req_ready_o` are both high. The first bus cycle follows in the next clock.
- R3: On the 16-bit bus, a byte access takes one cycle. At an even address only `mem_en_even_o` is high and the byte sits on bits [7:0]. At an odd address only `mem_en_odd_o` is high and the byte sits on bits [15:8].
- R4: On the 16-bit bus, a word at an even address takes one cycle with both enables high and the full word on `mem_wdata_o`.
- R5: On the 16-bit bus, a word at an odd address takes two cycles. The first cycle drives the odd address with the odd enable and the low byte on bits [15:8]. The second drives address+1 with the even enable and the high byte on bits [7:0].
- R6: The second address of a split word wraps modulo 2^20, so FFFFFh is followed by 00000h.
- R7: Read data on `rdata_o` is right-aligned. A byte read returns the byte in bits [7:0] with zeros above. A word read returns the lower-address byte in [7:0] and the next byte in [15:8].
- R8: `done_o` is high for exactly one clock, namely the clock after the final bus cycle. It is low during bus cycles. `rdata_o` is valid while `done_o` is high.
- R9: With `BUS8`=1, `mem_en_odd_o` stays low and all data uses bits [7:0] with `mem_en_even_o` as the single enable. Every word takes two cycles, at address and address+1, low byte first.
- R10: `mem_we_o` is high in every bus cycle of a write request and in no other clock. Writes store the bytes little-endian.
- R11: When no bus cycle is in progress, both enables and `mem_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seg_bases_i | input | 64 | Four packed segment bases (code, data, extra, stack) |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Sequencer idle and able to accept |
| req_seg_i | input | 2 | Segment select |
| req_off_i | input | 16 | Offset within segment |
| req_word_i | input | 1 | 1 = word, 0 = byte |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 16 | Write data, right-aligned |
| done_o | output | 1 | One-clock completion strobe |
| rdata_o | output | 16 | Right-aligned read data |
| mem_addr_o | output | 20 | Physical byte address of the current bus cycle |
| mem_en_even_o | output | 1 | Even bank (or single bank) enable |
| mem_en_odd_o | output | 1 | Odd bank enable |
| mem_we_o | output | 1 | Write strobe |
| mem_wdata_o | output | 16 | Memory write data lanes |
| mem_rdata_i | input | 16 | Memory read data lanes |

## Verification
On every clock, the assertions check these properties:

- Both bank enables appear together only at an even address.
- The write strobe never appears without a bank enable.
- The bus is quiet in idle.
- The completion strobe never lasts two clocks.
- An accepted request always starts a bus cycle.
- The second byte cycle sits exactly one address above the first.

Address formation, lane steering of each byte, right-alignment of read data and the little-endian contents left in memory can only be shown by the bench. It runs byte and word reads and writes at even and odd addresses, through each segment, across the 2^20 wrap, and on both bus widths.

// File: rtl/segseq_pkg.sv
package segseq_pkg;

    typedef enum logic [1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_EXTRA = 2'd2,
        SEG_STACK = 2'd3
    } seg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2,
        ST_DONE   = 2'd3
    } seq_state_e;

endpackage

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    parameter int NSEG  = 4,
    localparam int SEL_W = $clog2(NSEG),
    localparam int PA_W  = SEG_W + SHIFT
) (
    input  logic [NSEG*SEG_W-1:0] seg_bases,
    input  logic [SEL_W-1:0]      sel,
    input  logic [OFF_W-1:0]      off,
    output logic [PA_W-1:0]       pa
);

    logic [SEG_W-1:0] bases [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_unpack
        assign bases[g] = seg_bases[g*SEG_W +: SEG_W];
    end

    logic [SEG_W-1:0] chosen;
    assign chosen = bases[sel];

    // scaled base plus zero-extended offset; carry past PA_W bits is dropped
    assign pa = {chosen, {SHIFT{1'b0}}} + {{(PA_W-OFF_W){1'b0}}, off};

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import segseq_pkg::*;
#(
    parameter int PA_W   = 20,
    parameter int DATA_W = 16,
    parameter bit BUS8   = 1'b0,
    localparam int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [PA_W-1:0]   pa_in,
    input  logic              word_in,
    input  logic              write_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [BYTE_W-1:0] rd_byte,
    input  logic [DATA_W-1:0] rd_word,
    output logic              ready,
    output logic              active,
    output logic              second,
    output logic              both,
    output logic              byte_idx,
    output logic [PA_W-1:0]   cur_addr,
    output logic              write_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);

    seq_state_e state, state_nx;

    logic [PA_W-1:0]   pa_q;
    logic              word_q;
    logic              split_q;
    logic [DATA_W-1:0] rdata_q;

    logic split_in;
    assign split_in = word_in & (BUS8 | pa_in[0]);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nx = ST_FIRST;
            ST_FIRST:  state_nx = split_q ? ST_SECOND : ST_DONE;
            ST_SECOND: state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // request capture and read assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pa_q    <= '0;
            word_q  <= 1'b0;
            split_q <= 1'b0;
            write_q <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    pa_q    <= pa_in;
                    word_q  <= word_in;
                    split_q <= split_in;
                    write_q <= write_in;
                    wdata_q <= wdata_in;
                    rdata_q <= '0;
                end
                ST_FIRST: begin
                    if (word_q && !split_q) rdata_q <= rd_word;
                    else                    rdata_q[BYTE_W-1:0] <= rd_byte;
                    if (split_q) pa_q <= pa_q + {{(PA_W-1){1'b0}}, 1'b1};
                end
                ST_SECOND: rdata_q[2*BYTE_W-1:BYTE_W] <= rd_byte;
                ST_DONE:   ;
                default:   ;
            endcase
        end
    end

    // outputs
    always_comb begin
        ready    = 1'b0;
        active   = 1'b0;
        second   = 1'b0;
        done     = 1'b0;
        cur_addr = '0;
        unique case (state)
            ST_IDLE:   ready = 1'b1;
            ST_FIRST:  begin active = 1'b1; cur_addr = pa_q; end
            ST_SECOND: begin active = 1'b1; second = 1'b1; cur_addr = pa_q; end
            ST_DONE:   done = 1'b1;
            default:   ;
        endcase
        both     = word_q & ~split_q;
        byte_idx = second;
        rdata    = rdata_q;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid) |=> (active && !second)); // R2

endmodule

// File: rtl/bank_lane_unit.sv
module bank_lane_unit #(
    parameter int DATA_W = 16,
    parameter bit BUS8   = 1'b0,
    localparam int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              write,
    input  logic              addr0,
    input  logic              both,
    input  logic              byte_idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              en_even,
    output logic              en_odd,
    output logic              we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [DATA_W-1:0] rd_word
);

    logic [BYTE_W-1:0] cur_byte;
    assign cur_byte = byte_idx ? wdata[2*BYTE_W-1:BYTE_W] : wdata[BYTE_W-1:0];
    assign we       = active & write;
    assign rd_word  = mem_rdata;

    if (BUS8) begin : g_narrow
        always_comb begin
            en_even   = active;
            en_odd    = 1'b0;
            mem_wdata = {{(DATA_W-BYTE_W){1'b0}}, cur_byte};
            rd_byte   = mem_rdata[BYTE_W-1:0];
        end
    end else begin : g_wide
        always_comb begin
            if (both) begin
                en_even   = active;
                en_odd    = active;
                mem_wdata = wdata;
            end else begin
                en_even   = active & ~addr0;
                en_odd    = active & addr0;
                mem_wdata = addr0 ? {cur_byte, {BYTE_W{1'b0}}}
                                  : {{BYTE_W{1'b0}}, cur_byte};
            end
            rd_byte = addr0 ? mem_rdata[2*BYTE_W-1:BYTE_W] : mem_rdata[BYTE_W-1:0];
        end
    end

    AST_PAIR_EVEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (en_even && en_odd) |-> !addr0); // R4

endmodule

// File: rtl/seg_mem_seq.sv
module seg_mem_seq #(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int SHIFT  = 4,
    parameter int NSEG   = 4,
    parameter int DATA_W = 16,
    parameter bit BUS8   = 1'b0,
    localparam int SEL_W = $clog2(NSEG),
    localparam int PA_W  = SEG_W + SHIFT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSEG*SEG_W-1:0]  seg_bases_i,
    input  logic                   req_valid_i,
    output logic                   req_ready_o,
    input  logic [SEL_W-1:0]       req_seg_i,
    input  logic [OFF_W-1:0]       req_off_i,
    input  logic                   req_word_i,
    input  logic                   req_write_i,
    input  logic [DATA_W-1:0]      req_wdata_i,
    output logic                   done_o,
    output logic [DATA_W-1:0]      rdata_o,
    output logic [PA_W-1:0]        mem_addr_o,
    output logic                   mem_en_even_o,
    output logic                   mem_en_odd_o,
    output logic                   mem_we_o,
    output logic [DATA_W-1:0]      mem_wdata_o,
    input  logic [DATA_W-1:0]      mem_rdata_i
);

    logic [PA_W-1:0]   pa;
    logic              active, second, both, byte_idx, write_q;
    logic [DATA_W-1:0] wdata_q, rd_word;
    logic [7:0]        rd_byte;

    seg_addr_gen #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .NSEG(NSEG)) u_agen (
        .seg_bases (seg_bases_i),
        .sel       (req_seg_i),
        .off       (req_off_i),
        .pa        (pa)
    );

    seq_fsm #(.PA_W(PA_W), .DATA_W(DATA_W), .BUS8(BUS8)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid_i),
        .pa_in     (pa),
        .word_in   (req_word_i),
        .write_in  (req_write_i),
        .wdata_in  (req_wdata_i),
        .rd_byte   (rd_byte),
        .rd_word   (rd_word),
        .ready     (req_ready_o),
        .active    (active),
        .second    (second),
        .both      (both),
        .byte_idx  (byte_idx),
        .cur_addr  (mem_addr_o),
        .write_q   (write_q),
        .wdata_q   (wdata_q),
        .done      (done_o),
        .rdata     (rdata_o)
    );

    bank_lane_unit #(.DATA_W(DATA_W), .BUS8(BUS8)) u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .write     (write_q),
        .addr0     (mem_addr_o[0]),
        .both      (both),
        .byte_idx  (byte_idx),
        .wdata     (wdata_q),
        .mem_rdata (mem_rdata_i),
        .en_even   (mem_en_even_o),
        .en_odd    (mem_en_odd_o),
        .we        (mem_we_o),
        .mem_wdata (mem_wdata_o),
        .rd_byte   (rd_byte),
        .rd_word   (rd_word)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready_o || done_o) |-> (!mem_en_even_o && !mem_en_odd_o && !mem_we_o)); // R11
    AST_WE_HAS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (mem_en_even_o || mem_en_odd_o)); // R10
    AST_SPLIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        second |-> (mem_addr_o == $past(mem_addr_o) + {{(PA_W-1){1'b0}}, 1'b1})); // R6

    if (!BUS8) begin : g_wide_chk
        AST_SECOND_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
            second |-> (!mem_addr_o[0] && mem_en_even_o && !mem_en_odd_o)); // R5
    end

endmodule

// File: tb/tb_seg_mem_seq.sv
module tb_seg_mem_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] seg_bases;
    logic        req_valid = 1'b0;
    logic        sel8 = 1'b0;
    logic [1:0]  req_seg = 2'd0;
    logic [15:0] req_off = 16'h0;
    logic        req_word = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = 16'h0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    // wide-bus instance
    logic        rdy16, done16, ee16, eo16, we16;
    logic [15:0] rd16, wd16, mr16;
    logic [19:0] a16;
    // narrow-bus instance
    logic        rdy8, done8, ee8, eo8, we8;
    logic [15:0] rd8, wd8, mr8;
    logic [19:0] a8;

    seg_mem_seq dut (
        .clk(clk), .rst_n(rst_n), .seg_bases_i(seg_bases),
        .req_valid_i(req_valid & ~sel8), .req_ready_o(rdy16),
        .req_seg_i(req_seg), .req_off_i(req_off), .req_word_i(req_word),
        .req_write_i(req_write), .req_wdata_i(req_wdata),
        .done_o(done16), .rdata_o(rd16), .mem_addr_o(a16),
        .mem_en_even_o(ee16), .mem_en_odd_o(eo16), .mem_we_o(we16),
        .mem_wdata_o(wd16), .mem_rdata_i(mr16)
    );

    seg_mem_seq #(.BUS8(1'b1)) dut8 (
        .clk(clk), .rst_n(rst_n), .seg_bases_i(seg_bases),
        .req_valid_i(req_valid & sel8), .req_ready_o(rdy8),
        .req_seg_i(req_seg), .req_off_i(req_off), .req_word_i(req_word),
        .req_write_i(req_write), .req_wdata_i(req_wdata),
        .done_o(done8), .rdata_o(rd8), .mem_addr_o(a8),
        .mem_en_even_o(ee8), .mem_en_odd_o(eo8), .mem_we_o(we8),
        .mem_wdata_o(wd8), .mem_rdata_i(mr8)
    );

    // behavioural memories, aliased on the low 10 address bits
    logic [7:0] m16 [1024];
    logic [7:0] m8  [1024];

    always_comb mr16 = {m16[{a16[9:1], 1'b1}], m16[{a16[9:1], 1'b0}]};
    always_comb mr8  = {8'h00, m8[a8[9:0]]};

    always @(posedge clk) begin
        if (we16 && ee16) m16[{a16[9:1], 1'b0}] <= wd16[7:0];
        if (we16 && eo16) m16[{a16[9:1], 1'b1}] <= wd16[15:8];
        if (we8 && ee8)   m8[a8[9:0]] <= wd8[7:0];
    end

    // observation mux
    logic        o_rdy, o_done, o_ee, o_eo, o_we;
    logic [15:0] o_rd, o_wd;
    logic [19:0] o_a;
    always_comb begin
        o_rdy  = sel8 ? rdy8  : rdy16;
        o_done = sel8 ? done8 : done16;
        o_ee   = sel8 ? ee8   : ee16;
        o_eo   = sel8 ? eo8   : eo16;
        o_we   = sel8 ? we8   : we16;
        o_rd   = sel8 ? rd8   : rd16;
        o_wd   = sel8 ? wd8   : wd16;
        o_a    = sel8 ? a8    : a16;
    end

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic logic [7:0] peek(input bit b8, input logic [19:0] a);
        return b8 ? m8[a[9:0]] : m16[a[9:0]];
    endfunction

    task automatic access(input bit b8, input logic [1:0] seg, input logic [15:0] off,
                          input bit word, input bit wr, input logic [15:0] wd);
        logic [19:0] pa, a;
        logic [15:0] base;
        logic [7:0]  lo, hi, lane;
        bit          split;
        int          ncyc;
        base  = seg_bases[seg*16 +: 16];
        pa    = {base, 4'h0} + {4'h0, off};
        split = word && (b8 || pa[0]);
        ncyc  = split ? 2 : 1;
        lo    = peek(b8, pa);
        hi    = peek(b8, pa + 20'd1);

        @(negedge clk);
        sel8 = b8; req_seg = seg; req_off = off; req_word = word;
        req_write = wr; req_wdata = wd; req_valid = 1'b1;
        chk("R2", "ready before request", {31'h0, o_rdy}, 32'h1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 0; c < ncyc; c++) begin
            a = pa + 20'(c);
            chk(c == 0 ? "R1" : "R6", "bus address", {12'h0, o_a}, {12'h0, a});
            chk("R8", "no done in bus cycle", {31'h0, o_done}, 32'h0);
            chk("R10", "write strobe", {31'h0, o_we}, {31'h0, wr});
            if (b8) begin
                chk("R9", "narrow enables", {30'h0, o_ee, o_eo}, 32'h2);
                if (wr) chk("R9", "narrow lane", {16'h0, o_wd[7:0]}, c == 0 ? wd[7:0] : wd[15:8]);
            end else if (word && !split) begin
                chk("R4", "aligned enables", {30'h0, o_ee, o_eo}, 32'h3);
                if (wr) chk("R4", "aligned data", {16'h0, o_wd}, {16'h0, wd});
            end else begin
                chk(split ? "R5" : "R3", "byte enables", {30'h0, o_ee, o_eo},
                    {30'h0, ~a[0], a[0]});
                lane = a[0] ? o_wd[15:8] : o_wd[7:0];
                if (wr) chk(split ? "R5" : "R3", "byte lane", {24'h0, lane},
                            {24'h0, (c == 0) ? wd[7:0] : wd[15:8]});
            end
            @(posedge clk);
            @(negedge clk);
        end
        chk("R8", "done after last cycle", {31'h0, o_done}, 32'h1);
        if (!wr)
            chk("R7", "read data", {16'h0, o_rd}, word ? {16'h0, hi, lo} : {24'h0, lo});
        else begin
            chk("R10", "stored low byte", {24'h0, peek(b8, pa)}, {24'h0, wd[7:0]});
            if (word) chk("R10", "stored high byte", {24'h0, peek(b8, pa + 20'd1)}, {24'h0, wd[15:8]});
        end
        @(posedge clk);
        @(negedge clk);
        chk("R8", "done one clock only", {31'h0, o_done}, 32'h0);
        chk("R2", "ready again", {31'h0, o_rdy}, 32'h1);
        chk("R11", "bus quiet", {29'h0, o_ee, o_eo, o_we}, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            m16[i] = 8'(i) ^ 8'hA5;
            m8[i]  = 8'(i) + 8'h3C;
        end
        // stack, extra, data, code
        seg_bases = {16'h0010, 16'hFFFF, 16'h0800, 16'h1234};
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R2", "reset ready", {31'h0, rdy16}, 32'h1);
        chk("R8", "reset done low", {30'h0, done16, done8}, 32'h0);
        chk("R11", "reset bus quiet", {26'h0, ee16, eo16, we16, ee8, eo8, we8}, 32'h0);
        rst_n = 1'b1;

        // wide bus
        access(1'b0, 2'd1, 16'h0010, 1'b0, 1'b0, 16'h0);     // R3 even byte read
        access(1'b0, 2'd1, 16'h0013, 1'b0, 1'b0, 16'h0);     // R3 odd byte read
        access(1'b0, 2'd0, 16'h0004, 1'b1, 1'b0, 16'h0);     // R4 aligned word, code seg
        access(1'b0, 2'd3, 16'h0021, 1'b1, 1'b0, 16'h0);     // R5 split word, stack seg
        access(1'b0, 2'd1, 16'h0031, 1'b0, 1'b1, 16'h00C7);  // R3 odd byte write
        access(1'b0, 2'd1, 16'h0030, 1'b0, 1'b1, 16'h0051);  // R3 even byte write
        access(1'b0, 2'd3, 16'h0040, 1'b1, 1'b1, 16'hBEEF);  // R4 aligned word write
        access(1'b0, 2'd3, 16'h0045, 1'b1, 1'b1, 16'h1357);  // R5 split word write
        access(1'b0, 2'd3, 16'h0045, 1'b1, 1'b0, 16'h0);     // R7 read back split word
        access(1'b0, 2'd2, 16'h000F, 1'b1, 1'b0, 16'h0);     // R6 wrap FFFFF->00000
        access(1'b0, 2'd2, 16'h000F, 1'b1, 1'b1, 16'hA1B2);  // R6 wrap write
        access(1'b0, 2'd2, 16'h0020, 1'b1, 1'b0, 16'h0);     // R1 sum wraps mod 2^20
        // narrow bus
        access(1'b1, 2'd1, 16'h0013, 1'b0, 1'b0, 16'h0);     // R9 byte
        access(1'b1, 2'd1, 16'h0010, 1'b1, 1'b0, 16'h0);     // R9 even word split
        access(1'b1, 2'd3, 16'h0023, 1'b1, 1'b1, 16'h6A7B);  // R9 odd word write
        access(1'b1, 2'd3, 16'h0023, 1'b1, 1'b0, 16'h0);     // R7 read back
        access(1'b1, 2'd2, 16'h000F, 1'b1, 1'b0, 16'h0);     // R6 narrow wrap

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule